// File: doc/BRIEF.md
# Four-Wide Register Rename Unit

This block sits between decode and the issue queue of an out-of-order core that keeps results in a physical register file rather than in the reorder buffer. Each cycle it accepts a group of up to four instructions. Every instruction names two source and one destination architectural register. For each instruction the block returns physical source tags, a freshly allocated destination tag, and the physical tag that the destination was mapped to before. The issue queue and the retirement logic use these values. A fresh tag for every write removes write-after-read and write-after-write hazards.

Dependencies inside one group are resolved by comparing each slot's sources with the destinations of all earlier slots in the same group. Spare tags come from a circular free list. Retirement hands the superseded tag back to that list. After each instruction is renamed, the block stores a full copy of the map table and the free-list read position under that instruction's 5-bit circular ID. A mispredict flush that names an ID then rewinds both in one cycle. Architectural register 31 is the hard zero and is never renamed.

Top module: `rename_group_unit`

## Requirements
- R1: After reset, architectural register i (0 to 31) maps to physical tag i. The free list holds tags 32 to 79 in ascending order. The next instruction ID is 0, no instruction is in flight, and `renReady` is 1.
- R2: A source that no earlier valid slot of the same group writes gets the tag that the map table holds for that register at the start of the cycle.
- R3: Each valid slot whose destination is not 31 takes the next tag from the head of the free list, in slot order. Its `prevTag` is the mapping its destination had just before that slot, so no destination ever reuses a live tag.
- R4: A source, or a destination's previous mapping, that matches the destination of one or more earlier valid slots in the group takes the new tag of the nearest (youngest) such slot.
- R5: Register 31 as a source yields tag 31. As a destination it yields `dstTag` 31 and `prevTag` 31, and it takes no tag from the free list.
- R6: `renReady` is 0 when the free tags are fewer than the non-31 destinations of the valid slots, or when the in-flight count plus the valid slots would exceed 32. In that case nothing is renamed and no state changes.
- R7: Valid slots get consecutive IDs modulo 32 in slot order, continuing from the last ID handed out. Invalid slots consume none.
- R8: `commitEn` retires the oldest in-flight instruction. If its destination was not 31, its previous tag is appended to the tail of the free list. `commitEn` has no effect when nothing is in flight.
- R9: `flushEn` with `flushId` makes the map table, from the next cycle on, equal to its state right after instruction `flushId` was renamed. Free-list allocation resumes right after that instruction's last allocation, the next ID is `flushId`+1, and younger instructions are discarded.
- R10: During a flush cycle `renReady` is 0 and the group is not renamed. A commit in the same cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | 4 | Per-slot valid for the rename group |
| srcAArch | input | 20 | First source architectural register, 5 bits per slot, slot 0 in the low bits |
| srcBArch | input | 20 | Second source architectural register, 5 bits per slot |
| dstArch | input | 20 | Destination architectural register, 5 bits per slot |
| renReady | output | 1 | Group is accepted this cycle |
| srcATag | output | 28 | First source physical tag, 7 bits per slot |
| srcBTag | output | 28 | Second source physical tag, 7 bits per slot |
| dstTag | output | 28 | Newly allocated destination tag, 7 bits per slot |
| prevTag | output | 28 | Previous destination mapping, 7 bits per slot |
| instId | output | 20 | Instruction ID assigned to each slot, 5 bits per slot |
| commitEn | input | 1 | Retire the oldest in-flight instruction |
| flushEn | input | 1 | Roll back to the checkpoint of `flushId` |
| flushId | input | 5 | ID of the youngest instruction that survives the flush |

## Verification
The assertions assume that a flush names an instruction that is still in flight. They also assume that retirement happens only for instructions that have been renamed. The random stimulus follows a shadow of the in-flight window and draws `flushId` only from between the oldest and youngest live IDs. It asserts `flushEn` only while something is in flight, and sometimes combines it with a commit. Register numbers are drawn mostly from a narrow range, plus register 31, so that dependencies inside a group and the zero-register path come up often. Directed groups cover the reset mapping and a filled in-flight window.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int GROUP     = 4;
  parameter int ARCH_REGS = 32;
  parameter int PHYS_REGS = 80;
  parameter int INFLIGHT  = 32;

  localparam int AW       = $clog2(ARCH_REGS);
  localparam int PW       = $clog2(PHYS_REGS);
  localparam int IW       = $clog2(INFLIGHT);
  localparam int FREE_MAX = PHYS_REGS - ARCH_REGS;
  localparam logic [AW-1:0] ZERO_ARCH = AW'(ARCH_REGS - 1);
  localparam logic [PW-1:0] ZERO_TAG  = PW'(ARCH_REGS - 1);

  // strobes from control to datapath
  typedef struct packed {
    logic                       fire;
    logic [GROUP-1:0]           slotGo;
    logic [GROUP-1:0]           slotAlloc;
    logic [GROUP-1:0][IW-1:0]   slotId;
    logic [GROUP-1:0][PW-1:0]   slotFlIdx;
    logic                       commitPush;
    logic [IW-1:0]              commitId;
    logic [PW-1:0]              pushIdx;
    logic                       flushGo;
    logic [IW-1:0]              flushId;
  } rnStrobe_t;

  // circular add on the free-list ring
  function automatic logic [PW-1:0] flAdd(input logic [PW-1:0] a, input int b);
    int s;
    s = int'(a) + b;
    if (s >= PHYS_REGS) s = s - PHYS_REGS;
    return PW'(s);
  endfunction
endpackage

// File: rtl/rn_ctrl.sv
module rn_ctrl
  import rn_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GROUP-1:0]      renValid,
  input  logic [GROUP*AW-1:0]   dstFlat,
  input  logic                  commitEn,
  input  logic                  flushEn,
  input  logic [IW-1:0]         flushId,
  output logic                  renReady,
  output rnStrobe_t             strobe
);
  logic [IW-1:0]   idHead, idTail;
  logic [IW:0]     inflCnt;
  logic [PW-1:0]   flHead, flTail, flCnt;
  logic [PW-1:0]   ckHead [INFLIGHT];
  logic [INFLIGHT-1:0] hasDst;

  logic [GROUP-1:0]         allocReq;
  logic [GROUP-1:0][PW-1:0] ckNext;
  int                       validCnt, needCnt, reclaimCnt;
  logic                     commitGo;

  always_comb begin
    int vp, ap;
    vp = 0;
    ap = 0;
    for (int k = 0; k < GROUP; k++) begin
      allocReq[k]         = renValid[k] && (dstFlat[k*AW +: AW] != ZERO_ARCH);
      strobe.slotId[k]    = idTail + IW'(vp);
      strobe.slotFlIdx[k] = flAdd(flHead, ap);
      if (renValid[k]) vp = vp + 1;
      if (allocReq[k]) ap = ap + 1;
      ckNext[k]           = flAdd(flHead, ap);
    end
    validCnt = vp;
    needCnt  = ap;
    reclaimCnt = int'(flTail) - int'(ckHead[flushId]);
    if (reclaimCnt < 0) reclaimCnt = reclaimCnt + PHYS_REGS;
  end

  assign renReady          = !flushEn && (needCnt <= int'(flCnt))
                             && (int'(inflCnt) + validCnt <= INFLIGHT);
  assign strobe.fire       = renReady && (|renValid);
  assign strobe.slotGo     = strobe.fire ? renValid : '0;
  assign strobe.slotAlloc  = allocReq;
  assign commitGo          = commitEn && (inflCnt != '0);
  assign strobe.commitId   = idHead;
  assign strobe.commitPush = commitGo && hasDst[idHead];
  assign strobe.pushIdx    = flTail;
  assign strobe.flushGo    = flushEn;
  assign strobe.flushId    = flushId;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idHead  <= '0;
      idTail  <= '0;
      inflCnt <= '0;
      flHead  <= '0;
      flTail  <= PW'(FREE_MAX % PHYS_REGS);
      flCnt   <= PW'(FREE_MAX);
      hasDst  <= '0;
    end else begin
      if (strobe.commitPush) flTail <= flAdd(flTail, 1);
      if (commitGo) idHead <= idHead + 1'b1;
      if (strobe.fire) begin
        for (int k = 0; k < GROUP; k++)
          if (strobe.slotGo[k]) hasDst[strobe.slotId[k]] <= allocReq[k];
        idTail  <= idTail + IW'(validCnt);
        flHead  <= flAdd(flHead, needCnt);
        inflCnt <= inflCnt + (IW+1)'(validCnt) - (IW+1)'(commitGo);
        flCnt   <= flCnt - PW'(needCnt) + PW'(strobe.commitPush);
      end else if (flushEn) begin
        idTail  <= flushId + 1'b1;
        inflCnt <= {1'b0, IW'(flushId - idHead)} + 1'b1 - (IW+1)'(commitGo);
        flHead  <= ckHead[flushId];
        flCnt   <= PW'(reclaimCnt) + PW'(strobe.commitPush);
      end else begin
        inflCnt <= inflCnt - (IW+1)'(commitGo);
        flCnt   <= flCnt + PW'(strobe.commitPush);
      end
    end
  end

  // free-list position after each instruction's own allocation
  always_ff @(posedge clk) begin
    if (strobe.fire)
      for (int k = 0; k < GROUP; k++)
        if (strobe.slotGo[k]) ckHead[strobe.slotId[k]] <= ckNext[k];
  end

  assert_free_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flCnt <= PW'(FREE_MAX));
  assert_window_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inflCnt <= (IW+1)'(INFLIGHT));
  assert_flush_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flushEn |-> ({1'b0, IW'(flushId - idHead)} < inflCnt));
  assert_flush_next_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flushEn |=> (idTail == IW'($past(flushId) + 1'b1)));
endmodule

// File: rtl/rn_dpath.sv
module rn_dpath
  import rn_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  rnStrobe_t            strobe,
  input  logic [GROUP*AW-1:0]  srcAFlat,
  input  logic [GROUP*AW-1:0]  srcBFlat,
  input  logic [GROUP*AW-1:0]  dstFlat,
  output logic [GROUP*PW-1:0]  srcATagFlat,
  output logic [GROUP*PW-1:0]  srcBTagFlat,
  output logic [GROUP*PW-1:0]  dstTagFlat,
  output logic [GROUP*PW-1:0]  prevTagFlat
);
  logic [PW-1:0] mapTbl  [ARCH_REGS];
  logic [PW-1:0] ckMap   [INFLIGHT][ARCH_REGS];
  logic [PW-1:0] flRam   [PHYS_REGS];
  logic [PW-1:0] prevRam [INFLIGHT];

  logic [PW-1:0] newTag  [GROUP];
  logic [PW-1:0] tagA    [GROUP];
  logic [PW-1:0] tagB    [GROUP];
  logic [PW-1:0] tagPrev [GROUP];
  logic [PW-1:0] mapAfter [GROUP][ARCH_REGS];

  // intra-group comparators: later match overrides, so the youngest earlier writer wins
  always_comb begin
    for (int k = 0; k < GROUP; k++) begin
      logic [AW-1:0] a, b, d;
      a = srcAFlat[k*AW +: AW];
      b = srcBFlat[k*AW +: AW];
      d = dstFlat[k*AW +: AW];
      newTag[k]  = strobe.slotAlloc[k] ? flRam[strobe.slotFlIdx[k]] : ZERO_TAG;
      tagA[k]    = mapTbl[a];
      tagB[k]    = mapTbl[b];
      tagPrev[k] = strobe.slotAlloc[k] ? mapTbl[d] : ZERO_TAG;
      for (int j = 0; j < k; j++) begin
        if (strobe.slotAlloc[j] && dstFlat[j*AW +: AW] == a) tagA[k] = newTag[j];
        if (strobe.slotAlloc[j] && dstFlat[j*AW +: AW] == b) tagB[k] = newTag[j];
        if (strobe.slotAlloc[k] && strobe.slotAlloc[j] && dstFlat[j*AW +: AW] == d)
          tagPrev[k] = newTag[j];
      end
      srcATagFlat[k*PW +: PW] = tagA[k];
      srcBTagFlat[k*PW +: PW] = tagB[k];
      dstTagFlat[k*PW +: PW]  = newTag[k];
      prevTagFlat[k*PW +: PW] = tagPrev[k];
    end
  end

  // map as seen after each slot, used for checkpoints and the table update
  always_comb begin
    for (int k = 0; k < GROUP; k++)
      for (int r = 0; r < ARCH_REGS; r++) begin
        if (k == 0) mapAfter[k][r] = mapTbl[r];
        else        mapAfter[k][r] = mapAfter[k-1][r];
        if (strobe.slotAlloc[k] && dstFlat[k*AW +: AW] == AW'(r))
          mapAfter[k][r] = newTag[k];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ARCH_REGS; r++) mapTbl[r] <= PW'(r);
    end else if (strobe.flushGo) begin
      mapTbl <= ckMap[strobe.flushId];
    end else if (strobe.fire) begin
      mapTbl <= mapAfter[GROUP-1];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fire)
      for (int k = 0; k < GROUP; k++)
        if (strobe.slotGo[k]) begin
          ckMap[strobe.slotId[k]]   <= mapAfter[k];
          prevRam[strobe.slotId[k]] <= tagPrev[k];
        end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_REGS; i++)
        flRam[i] <= (i < FREE_MAX) ? PW'(ARCH_REGS + i) : '0;
    end else if (strobe.commitPush) begin
      flRam[strobe.pushIdx] <= prevRam[strobe.commitId];
    end
  end

  for (genvar k = 0; k < GROUP; k++) begin : g_chk
    assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.slotGo[k] && srcAFlat[k*AW +: AW] == ZERO_ARCH) |-> (tagA[k] == ZERO_TAG));
    assert_fresh_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.slotGo[k] && strobe.slotAlloc[k]) |-> (newTag[k] != ZERO_TAG && newTag[k] != tagPrev[k]));
    for (genvar j = 0; j < k; j++) begin : g_pair
      assert_distinct_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe.slotGo[k] && strobe.slotAlloc[k] && strobe.slotGo[j] && strobe.slotAlloc[j])
          |-> (newTag[k] != newTag[j]));
    end
  end
endmodule

// File: rtl/rename_group_unit.sv
module rename_group_unit
  import rn_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GROUP-1:0]     renValid,
  input  logic [GROUP*AW-1:0]  srcAArch,
  input  logic [GROUP*AW-1:0]  srcBArch,
  input  logic [GROUP*AW-1:0]  dstArch,
  output logic                 renReady,
  output logic [GROUP*PW-1:0]  srcATag,
  output logic [GROUP*PW-1:0]  srcBTag,
  output logic [GROUP*PW-1:0]  dstTag,
  output logic [GROUP*PW-1:0]  prevTag,
  output logic [GROUP*IW-1:0]  instId,
  input  logic                 commitEn,
  input  logic                 flushEn,
  input  logic [IW-1:0]        flushId
);
  rnStrobe_t strobe;

  rn_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .dstFlat(dstArch),
    .commitEn(commitEn), .flushEn(flushEn), .flushId(flushId),
    .renReady(renReady), .strobe(strobe)
  );

  rn_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .srcAFlat(srcAArch), .srcBFlat(srcBArch), .dstFlat(dstArch),
    .srcATagFlat(srcATag), .srcBTagFlat(srcBTag),
    .dstTagFlat(dstTag), .prevTagFlat(prevTag)
  );

  assign instId = strobe.slotId;
endmodule

// File: tb/rename_group_unit_tb.sv
`timescale 1ns/1ps
module rename_group_unit_tb;
  import rn_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [GROUP-1:0]    renValid = '0;
  logic [GROUP*AW-1:0] srcAArch = '0, srcBArch = '0, dstArch = '0;
  logic                renReady;
  logic [GROUP*PW-1:0] srcATag, srcBTag, dstTag, prevTag;
  logic [GROUP*IW-1:0] instId;
  logic                commitEn = 1'b0, flushEn = 1'b0;
  logic [IW-1:0]       flushId = '0;

  always #2.5 clk = ~clk;

  rename_group_unit u_dut (.*);

  int nChecks = 0, nFails = 0;
  int mMap[ARCH_REGS];
  int mCk[INFLIGHT][ARCH_REGS];
  int mCkFl[INFLIGHT];
  int mPrev[INFLIGHT];
  bit mHasDst[INFLIGHT];
  int mFl[PHYS_REGS];
  int mFlHead, mFlTail, mIdHead, mIdTail, mInfl;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int flFree();
    return (mFlTail - mFlHead + PHYS_REGS) % PHYS_REGS;
  endfunction

  task automatic modelReset();
    for (int r = 0; r < ARCH_REGS; r++) mMap[r] = r;
    for (int i = 0; i < PHYS_REGS; i++) mFl[i] = (i < FREE_MAX) ? ARCH_REGS + i : 0;
    mFlHead = 0; mFlTail = FREE_MAX % PHYS_REGS;
    mIdHead = 0; mIdTail = 0; mInfl = 0;
  endtask

  function automatic int fld5(logic [GROUP*AW-1:0] v, int k);
    return int'(v[k*AW +: AW]);
  endfunction

  // one cycle: inputs already driven after a falling edge
  task automatic step();
    int need, nv, oldHead, tmp[ARCH_REGS], fl, id;
    bit wr[ARCH_REGS];
    bit expReady, didCommit;
    #1;
    need = 0; nv = 0;
    for (int k = 0; k < GROUP; k++)
      if (renValid[k]) begin
        nv++;
        if (fld5(dstArch, k) != ARCH_REGS - 1) need++;
      end
    expReady = !flushEn && need <= flFree() && mInfl + nv <= INFLIGHT;
    check(flushEn ? "R10" : "R6", int'(renReady), int'(expReady));
    oldHead = mIdHead;
    if (expReady && nv > 0) begin
      tmp = mMap; fl = mFlHead; id = mIdTail;
      for (int r = 0; r < ARCH_REGS; r++) wr[r] = 0;
      for (int k = 0; k < GROUP; k++) begin
        int a, b, d, nt, pv;
        if (!renValid[k]) continue;
        a = fld5(srcAArch, k); b = fld5(srcBArch, k); d = fld5(dstArch, k);
        check(a == ARCH_REGS-1 ? "R5" : (wr[a] ? "R4" : "R2"),
              int'(srcATag[k*PW +: PW]), tmp[a]);
        check(b == ARCH_REGS-1 ? "R5" : (wr[b] ? "R4" : "R2"),
              int'(srcBTag[k*PW +: PW]), tmp[b]);
        if (d != ARCH_REGS - 1) begin
          nt = mFl[fl]; fl = (fl + 1) % PHYS_REGS; pv = tmp[d];
          check(wr[d] ? "R4" : "R3", int'(prevTag[k*PW +: PW]), pv);
          check("R3", int'(dstTag[k*PW +: PW]), nt);
          tmp[d] = nt; wr[d] = 1;
        end else begin
          pv = ARCH_REGS - 1;
          check("R5", int'(dstTag[k*PW +: PW]), ARCH_REGS - 1);
          check("R5", int'(prevTag[k*PW +: PW]), ARCH_REGS - 1);
        end
        check("R7", int'(instId[k*IW +: IW]), id);
        mCk[id] = tmp; mCkFl[id] = fl; mPrev[id] = pv; mHasDst[id] = (d != ARCH_REGS - 1);
        id = (id + 1) % INFLIGHT;
      end
      mMap = tmp; mFlHead = fl; mIdTail = id; mInfl += nv;
    end
    didCommit = commitEn && mInfl > 0 && !(expReady && nv > 0 && mInfl == nv);
    if (commitEn && (mInfl - ((expReady && nv > 0) ? nv : 0)) > 0) begin
      if (mHasDst[oldHead]) begin
        mFl[mFlTail] = mPrev[oldHead];
        mFlTail = (mFlTail + 1) % PHYS_REGS;
      end
      mIdHead = (mIdHead + 1) % INFLIGHT;
      mInfl--;
      didCommit = 1;
    end else didCommit = 0;
    if (flushEn) begin
      mInfl = ((int'(flushId) - oldHead) & (INFLIGHT - 1)) + 1 - (didCommit ? 1 : 0);
      mIdTail = (int'(flushId) + 1) % INFLIGHT;
      mMap = mCk[flushId];
      mFlHead = mCkFl[flushId];
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int pickReg(bit wide);
    int r;
    r = $urandom % 10;
    if (r == 0) return ARCH_REGS - 1;
    return wide ? ($urandom % (ARCH_REGS - 1)) : ($urandom % 6);
  endfunction

  task automatic driveIdle();
    renValid = '0; commitEn = 0; flushEn = 0;
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1152));
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset mapping and first allocations
    srcAArch = {5'd31, 5'd9, 5'd0, 5'd5};
    srcBArch = {5'd30, 5'd2, 5'd1, 5'd17};
    dstArch  = {5'd31, 5'd3, 5'd3, 5'd3};
    renValid = 4'b1111;
    #1;
    check("R1", int'(renReady), 1);
    check("R1", int'(srcATag[0 +: PW]), 5);
    check("R1", int'(srcBTag[0 +: PW]), 17);
    check("R1", int'(dstTag[0 +: PW]), 32);
    check("R1", int'(instId[0 +: IW]), 0);
    check("R4", int'(prevTag[2*PW +: PW]), 33);
    step();
    // R6/R7: fill the in-flight window, then stall
    for (int g = 0; g < 8; g++) begin
      renValid = 4'b1111;
      for (int k = 0; k < GROUP; k++) begin
        srcAArch[k*AW +: AW] = AW'(pickReg(1));
        srcBArch[k*AW +: AW] = AW'(pickReg(1));
        dstArch[k*AW +: AW]  = AW'(pickReg(1));
      end
      step();
    end
    renValid = 4'b0001; step();
    commitEn = 1; renValid = 4'b0001; step();
    commitEn = 0; renValid = 4'b0001; step();
    // R9/R10: flush back to an older live instruction
    driveIdle(); flushEn = 1; flushId = IW'((mIdHead + 3) % INFLIGHT); renValid = 4'b1111; step();
    driveIdle(); renValid = 4'b1111; step();
    // R8: drain with commits
    driveIdle();
    for (int i = 0; i < 40; i++) begin commitEn = 1; step(); end
    // random mix
    for (int c = 0; c < 4000; c++) begin
      bit wide = ($urandom % 4 == 0);
      renValid = GROUP'($urandom);
      for (int k = 0; k < GROUP; k++) begin
        srcAArch[k*AW +: AW] = AW'(pickReg(wide));
        srcBArch[k*AW +: AW] = AW'(pickReg(wide));
        dstArch[k*AW +: AW]  = AW'(pickReg(wide));
      end
      commitEn = ($urandom % 3 == 0);
      flushEn = (mInfl > 0) && ($urandom % 24 == 0);
      flushId = IW'((mIdHead + (mInfl > 0 ? ($urandom % mInfl) : 0)) % INFLIGHT);
      step();
    end
    driveIdle();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule